// File: doc/BRIEF.md
# UART Interrupt Aggregation Unit

This block gathers the interrupt causes of a UART into one bank of sticky status bits. The causes are three line errors (break, parity, framing), the transmit and receive level conditions, and an internal receive-timeout detector. Each source sets its bit on a one-cycle event pulse. A mask register selects which bits may drive the single interrupt request line. Software can read the raw bits and the masked bits at all times, and clears them by writing ones.

The receive-timeout detector counts bit-period ticks while the receive FIFO holds data. Each arriving character restarts the count from zero, and the count stays at zero while the FIFO is empty. When the idle count reaches the configured number of bit periods, the timeout bit is set. The bit drops by itself once the FIFO drains. It also drops when software writes its clear bit.

Top module: `uart_irq_agg`

## Requirements
- R1: After reset, the raw status, the masked status and the mask all read 0, and `irq` is low.
- R2: The status, mask and clear bit positions are: bit 0 receive level, bit 1 transmit level, bit 2 receive timeout, bit 3 framing error, bit 4 parity error, bit 5 break error.
- R3: A one-cycle pulse on an event input sets its raw bit at the next clock edge. The bit stays set, and it is visible in `raw_stat` whatever the mask holds.
- R4: `masked_stat` equals `raw_stat` AND the mask register, and `irq` is high exactly when any bit of `masked_stat` is 1. A mask write takes effect at the next edge.
- R5: A clear write with a 1 in a bit position clears that raw bit, which also removes it from `masked_stat`. Bits written as 0 are left unchanged.
- R6: When an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R7: While the RX FIFO is non-empty and no character arrives, the timeout bit is set at the edge of the 32nd bit-period tick (`IDLE_BITS`), and not before it.
- R8: A character arrival strobe restarts the idle count from zero. The timeout then needs a further 32 ticks.
- R9: While the RX FIFO is empty, the idle count holds at zero, and the timeout bit clears at the next edge.
- R10: The timeout bit fires at most once per idle interval. After it is cleared by a write, further ticks do not set it again until a character arrives or the FIFO empties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_break | input | 1 | Break error event pulse |
| ev_parity | input | 1 | Parity error event pulse |
| ev_frame | input | 1 | Framing error event pulse |
| tx_lvl_hit | input | 1 | Transmit level reached pulse |
| rx_lvl_hit | input | 1 | Receive level reached pulse |
| rx_fifo_empty | input | 1 | RX FIFO holds no data |
| rx_char_strobe | input | 1 | A character entered the RX FIFO |
| bit_tick | input | 1 | One pulse per serial bit period |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 6 | Mask write data |
| clr_we | input | 1 | Clear write enable |
| clr_wdata | input | 6 | Clear write data, ones clear |
| raw_stat | output | 6 | Raw status bits |
| masked_stat | output | 6 | Raw status AND mask |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is the timeout boundary: the bit must stay low after 31 idle ticks and rise on the 32nd. The bench drives ticks one at a time and checks both counts. It repeats this after a mid-count character strobe, after a long run with the FIFO empty, and after a clear, to confirm that the count restarted or stayed frozen. A second case that needs exact timing is an event and a clear of the same bit in one cycle. The bench places both on the same edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC       = 6;
  localparam int IDX_RXLVL  = 0;
  localparam int IDX_TXLVL  = 1;
  localparam int IDX_RXTO   = 2;
  localparam int IDX_FRAME  = 3;
  localparam int IDX_PARITY = 4;
  localparam int IDX_BREAK  = 5;

  function automatic logic [NSRC-1:0] gate_mask(input logic [NSRC-1:0] raw,
                                                input logic [NSRC-1:0] msk);
    return raw & msk;
  endfunction

  function automatic logic any_set(input logic [NSRC-1:0] v);
    return |v;
  endfunction
endpackage

// File: rtl/irq_status_bit.sv
module irq_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic auto_clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 q_o <= 1'b0;
    else if (set_i)             q_o <= 1'b1;
    else if (clr_i || auto_clr_i) q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && !auto_clr_i) |=> (q_o == $past(q_o))); // R3
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int IDLE_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_empty_i,
  input  logic char_strobe_i,
  input  logic tick_i,
  output logic fire_o,
  output logic cnt_zero_o
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_BITS);

  logic [CW-1:0] cnt_q;
  logic          restart;
  logic          advance;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return (c == LIMIT) ? c : c + 1'b1;
  endfunction

  assign restart    = fifo_empty_i || char_strobe_i;
  assign advance    = tick_i && !restart;
  assign fire_o     = advance && (cnt_q == LIMIT - 1'b1);
  assign cnt_zero_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (advance) cnt_q <= bump(cnt_q);
  end

  AST_EMPTY_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty_i |=> cnt_zero_o); // R9
  AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    char_strobe_i |=> cnt_zero_o); // R8
  AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o); // R10
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
  import uart_irq_pkg::*;
#(
  parameter int IDLE_BITS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_break,
  input  logic            ev_parity,
  input  logic            ev_frame,
  input  logic            tx_lvl_hit,
  input  logic            rx_lvl_hit,
  input  logic            rx_fifo_empty,
  input  logic            rx_char_strobe,
  input  logic            bit_tick,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_wdata,
  output logic [NSRC-1:0] raw_stat,
  output logic [NSRC-1:0] masked_stat,
  output logic            irq
);
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] auto_vec;
  logic [NSRC-1:0] mask_q;
  logic            to_fire;
  logic            to_cnt_zero;

  rx_idle_timer #(.IDLE_BITS(IDLE_BITS)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_empty_i  (rx_fifo_empty),
    .char_strobe_i (rx_char_strobe),
    .tick_i        (bit_tick),
    .fire_o        (to_fire),
    .cnt_zero_o    (to_cnt_zero)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[IDX_RXLVL]  = rx_lvl_hit;
    set_vec[IDX_TXLVL]  = tx_lvl_hit;
    set_vec[IDX_RXTO]   = to_fire;
    set_vec[IDX_FRAME]  = ev_frame;
    set_vec[IDX_PARITY] = ev_parity;
    set_vec[IDX_BREAK]  = ev_break;
    auto_vec            = '0;
    auto_vec[IDX_RXTO]  = rx_fifo_empty;
  end

  assign clr_vec = clr_we ? clr_wdata : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    irq_status_bit u_bit (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_vec[i]),
      .clr_i      (clr_vec[i]),
      .auto_clr_i (auto_vec[i]),
      .q_o        (raw_stat[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign masked_stat = gate_mask(raw_stat, mask_q);
  assign irq         = any_set(masked_stat);

  AST_TO_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_empty |=> !raw_stat[IDX_RXTO]); // R9
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_stat != '0)); // R4
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && mask_wdata == '0) |=> !irq); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (raw_stat == '0 && !irq)); // R1
  AST_TO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_stat[IDX_RXTO]) |-> !$past(rx_fifo_empty)); // R7
endmodule

// File: tb/sim_uart_irq_agg.sv
module sim_uart_irq_agg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_break = 0, ev_parity = 0, ev_frame = 0;
  logic       tx_lvl_hit = 0, rx_lvl_hit = 0;
  logic       rx_fifo_empty = 1, rx_char_strobe = 0, bit_tick = 0;
  logic       mask_we = 0, clr_we = 0;
  logic [5:0] mask_wdata = 0, clr_wdata = 0;
  logic [5:0] raw_stat, masked_stat;
  logic       irq;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  uart_irq_agg #(.IDLE_BITS(32)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_break(ev_break), .ev_parity(ev_parity),
    .ev_frame(ev_frame), .tx_lvl_hit(tx_lvl_hit), .rx_lvl_hit(rx_lvl_hit),
    .rx_fifo_empty(rx_fifo_empty), .rx_char_strobe(rx_char_strobe),
    .bit_tick(bit_tick), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata), .raw_stat(raw_stat),
    .masked_stat(masked_stat), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      bit_tick = 1; step(); bit_tick = 0;
    end
  endtask

  task automatic wr_mask(input logic [5:0] v);
    mask_we = 1; mask_wdata = v; step(); mask_we = 0;
  endtask

  task automatic wr_clr(input logic [5:0] v);
    clr_we = 1; clr_wdata = v; step(); clr_we = 0; clr_wdata = 0;
  endtask

  task automatic t_reset();
    chk("R1", "raw", raw_stat, 0);
    chk("R1", "masked", masked_stat, 0);
    chk("R1", "irq", irq, 0);
    wr_mask(6'h3f);
    chk("R1", "raw after full mask", raw_stat, 0);
    chk("R1", "irq after full mask", irq, 0);
    wr_mask(6'h00);
  endtask

  task automatic t_events();
    rx_lvl_hit = 1; step(); rx_lvl_hit = 0;
    chk("R2", "rx level bit0", raw_stat, 6'h01);
    tx_lvl_hit = 1; step(); tx_lvl_hit = 0;
    chk("R2", "tx level bit1", raw_stat, 6'h03);
    ev_frame = 1; step(); ev_frame = 0;
    chk("R2", "frame bit3", raw_stat, 6'h0b);
    ev_parity = 1; step(); ev_parity = 0;
    chk("R2", "parity bit4", raw_stat, 6'h1b);
    ev_break = 1; step(); ev_break = 0;
    chk("R2", "break bit5", raw_stat, 6'h3b);
    step(); step();
    chk("R3", "sticky with mask 0", raw_stat, 6'h3b);
    chk("R3", "masked with mask 0", masked_stat, 0);
    chk("R3", "irq with mask 0", irq, 0);
  endtask

  task automatic t_mask();
    wr_mask(6'h10);
    chk("R4", "masked parity only", masked_stat, 6'h10);
    chk("R4", "irq parity", irq, 1);
    chk("R4", "raw unaffected by mask", raw_stat, 6'h3b);
    wr_mask(6'h04);
    chk("R4", "masked timeout only", masked_stat, 0);
    chk("R4", "irq no cause", irq, 0);
  endtask

  task automatic t_clear();
    wr_clr(6'h00);
    chk("R5", "zero clear no effect", raw_stat, 6'h3b);
    wr_mask(6'h3f);
    wr_clr(6'h10);
    chk("R5", "parity cleared", raw_stat, 6'h2b);
    chk("R5", "masked follows", masked_stat, 6'h2b);
    wr_clr(6'h2b);
    chk("R5", "all cleared", raw_stat, 0);
    chk("R5", "irq low after clear", irq, 0);
  endtask

  task automatic t_set_wins();
    ev_break = 1; clr_we = 1; clr_wdata = 6'h20; step();
    ev_break = 0; clr_we = 0; clr_wdata = 0;
    chk("R6", "break kept over clear", raw_stat, 6'h20);
    chk("R6", "irq kept", irq, 1);
    wr_clr(6'h20);
    chk("R6", "later clear works", raw_stat, 0);
  endtask

  task automatic t_timeout();
    rx_fifo_empty = 1; ticks(50);
    chk("R9", "no timeout while empty", raw_stat[2], 0);
    rx_fifo_empty = 0; ticks(31);
    chk("R7", "not set after 31 ticks", raw_stat[2], 0);
    ticks(1);
    chk("R7", "set on 32nd tick", raw_stat[2], 1);
    chk("R4", "timeout drives irq", irq, 1);
    ticks(40);
    chk("R10", "still set with more ticks", raw_stat[2], 1);
    wr_clr(6'h04);
    chk("R10", "cleared by write", raw_stat[2], 0);
    ticks(40);
    chk("R10", "no refire in same interval", raw_stat[2], 0);
    rx_char_strobe = 1; step(); rx_char_strobe = 0;
    ticks(20);
    rx_char_strobe = 1; step(); rx_char_strobe = 0;
    ticks(31);
    chk("R8", "restart: not set after 31", raw_stat[2], 0);
    ticks(1);
    chk("R8", "restart: set on 32nd", raw_stat[2], 1);
    rx_fifo_empty = 1; step();
    chk("R9", "auto clear on empty", raw_stat[2], 0);
    chk("R9", "irq drops", irq, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset();
    t_events();
    t_mask();
    t_clear();
    t_set_wins();
    t_timeout();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule